// File: doc/BRIEF.md
# Time-of-Year Calendar Counter

This block keeps a running calendar date and time of day. A slow oscillator delivers a one-cycle tick enable into the system clock domain. A prescaler divides those ticks into sixteen sub-second steps per second. Each step advances a carry chain through sub-second, second, minute, hour, day of month, month and a full 32-bit year.

Software reaches the block through a simple 32-bit register port at a 4-byte stride, with a write strobe and a combinational read. The time is set through a packed date/time word and, separately, through a year word. Both setting registers are write-only. The running value is read back through two read-only registers at other addresses. A control register gates counting. It advances only when the count-enable bit and the oscillator-enable bit are both set. A trim register exists in the map but always holds zero.

Register map (byte offsets): 0x00 control, 0x04 trim, 0x08 time set (write-only), 0x0C year set (write-only), 0x10 time read (read-only), 0x14 year read (read-only). Any other offset reads zero.

Top module: `toy_clock`

## Requirements
- R1: After reset, the time read register returns 0x04200000 (month 1, day 1, 00:00:00, sub-second 0). The year read register and the control register both return 0.
- R2: The control register keeps bit 13 (seconds-counter enable), bit 11 (count enable) and bit 8 (oscillator enable). Every other bit reads as 0.
- R3: The calendar advances only when control bits 11 and 8 are both set. With either bit clear, oscillator ticks leave the time and the year unchanged.
- R4: The trim register reads 0 at all times, and writes to it have no effect.
- R5: The sub-second field advances once every TICKS_PER_STEP qualifying oscillator ticks (default 2048). It wraps from 15 to 0 and increments the second.
- R6: Seconds and minutes wrap from 59 to 0, and hours wrap from 23 to 0. Each wrap increments the next field up.
- R7: The day wraps to 1 after the last day of the current month and increments the month. April, June, September and November have 30 days; February has 28, or 29 in a leap year; all other months have 31. The month wraps from 12 to 1 and increments the year.
- R8: Every year divisible by 4 is a leap year, with no century exception. For example, 2100 is a leap year and 2023 is not.
- R9: The packed time word holds the month (1 to 12) in bits 31:26, the day in 25:21, the hour in 20:16, the minute in 15:10, the second in 9:4 and the sub-second in 3:0. A write to the time-set register loads all of these fields at the next clock edge. The same write restarts the prescaler, so the next step needs a full TICKS_PER_STEP ticks.
- R10: A write to the year-set register loads the 32-bit year alone and leaves the packed time fields unchanged.
- R11: The two set registers read as 0. Writes to the two read registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-cycle enable per oscillator period |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |

## Verification
The hardest situation to reach from the ports is a carry that ripples through every field at once, such as the last sub-second of the last day of a month. Waiting for it in real time would take years of ticks. The stimulus gets there by loading the time word and the year directly to one step before each boundary, and then issuing exactly one prescaler period of ticks. It does this for every month across leap, non-leap and century years, and for every second, minute and hour value. A small prescaler setting keeps each step short.

// File: rtl/toy_pkg.sv
package toy_pkg;

  typedef struct packed {
    logic [5:0] mon;
    logic [4:0] day;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
    logic [3:0] sub;
  } toy_time_t;

  localparam int IDX_CTRL   = 0;
  localparam int IDX_TRIM   = 1;
  localparam int IDX_SET_LO = 2;
  localparam int IDX_SET_YR = 3;
  localparam int IDX_GET_LO = 4;
  localparam int IDX_GET_YR = 5;

  localparam int BIT_SEC_EN = 13;
  localparam int BIT_CNT_EN = 11;
  localparam int BIT_OSC_EN = 8;

  localparam toy_time_t TIME_RESET = '{mon: 6'd1, day: 5'd1, hour: 5'd0,
                                       min: 6'd0, sec: 6'd0, sub: 4'd0};

  function automatic logic is_leap(input logic [31:0] year);
    return (year[1:0] == 2'b00);
  endfunction

  function automatic logic [4:0] days_in_month(input logic [5:0] mon,
                                               input logic leap);
    case (mon)
      6'd2:                       return leap ? 5'd29 : 5'd28;
      6'd4, 6'd6, 6'd9, 6'd11:    return 5'd30;
      default:                    return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/toy_prescaler.sv
module toy_prescaler #(
  parameter int TICKS_PER_STEP = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic clear,
  output logic step
);

  localparam int PW = (TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_STEP - 1);

  generate
    if (TICKS_PER_STEP > 1) begin : g_div
      logic [PW-1:0] cnt;
      logic          at_last;
      assign at_last = (cnt == LAST);
      assign step    = run && tick && at_last && !clear;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt <= '0;
        else if (clear)           cnt <= '0;
        else if (run && tick)     cnt <= at_last ? '0 : cnt + 1'b1;
      end

      a_r5_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
      a_r9_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0) && !step);
    end else begin : g_direct
      assign step = run && tick && !clear;
    end
  endgenerate

  a_r3_step_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (run && tick));

endmodule

// File: rtl/toy_calendar.sv
module toy_calendar
  import toy_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  input  logic        load_low,
  input  logic [31:0] low_in,
  input  logic        load_year,
  input  logic [31:0] year_in,
  output logic [31:0] low_out,
  output logic [31:0] year_out
);

  toy_time_t   t, nt;
  logic [31:0] year_q, ny;
  logic [4:0]  dim;
  logic        sub_wrap, sec_wrap, min_wrap, hr_wrap, day_wrap, mon_wrap;

  assign dim      = days_in_month(t.mon, is_leap(year_q));
  assign sub_wrap = step && (t.sub == 4'hF);
  assign sec_wrap = sub_wrap && (t.sec >= 6'd59);
  assign min_wrap = sec_wrap && (t.min >= 6'd59);
  assign hr_wrap  = min_wrap && (t.hour >= 5'd23);
  assign day_wrap = hr_wrap && (t.day >= dim);
  assign mon_wrap = day_wrap && (t.mon >= 6'd12);

  always_comb begin
    nt = t;
    ny = year_q;
    if (step)     nt.sub  = t.sub + 4'd1;
    if (sub_wrap) nt.sec  = sec_wrap ? 6'd0 : t.sec + 6'd1;
    if (sec_wrap) nt.min  = min_wrap ? 6'd0 : t.min + 6'd1;
    if (min_wrap) nt.hour = hr_wrap  ? 5'd0 : t.hour + 5'd1;
    if (hr_wrap)  nt.day  = day_wrap ? 5'd1 : t.day + 5'd1;
    if (day_wrap) nt.mon  = mon_wrap ? 6'd1 : t.mon + 6'd1;
    if (mon_wrap) ny      = year_q + 32'd1;
    if (load_low)  nt = toy_time_t'(low_in);
    if (load_year) ny = year_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t      <= TIME_RESET;
      year_q <= '0;
    end else begin
      t      <= nt;
      year_q <= ny;
    end
  end

  assign low_out  = t;
  assign year_out = year_q;

  a_r6_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_wrap && t.sec == 6'd59 && !load_low) |=> (t.sec == 6'd0));
  a_r7_day_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_wrap && t.day == dim && !load_low) |=> (t.day == 5'd1));
  a_r7_year_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_wrap && !load_year) |=> (year_q == $past(year_q) + 32'd1));
  a_r10_year_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load_year && !load_low && !step) |=> (year_q == $past(year_in)) && $stable(t));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load_low && !load_year) |=> $stable(t) && $stable(year_q));

endmodule

// File: rtl/toy_clock.sv
module toy_clock
  import toy_pkg::*;
#(
  parameter int TICKS_PER_STEP = 2048,
  parameter int ADDR_W         = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] widx;
  logic             sec_en, cnt_en, osc_en;
  logic             run, step, load_low, load_year;
  logic [31:0]      low_out, year_out, ctrl_view;

  assign widx      = bus_addr[ADDR_W-1:2];
  assign load_low  = bus_we && (widx == IDX_W'(IDX_SET_LO));
  assign load_year = bus_we && (widx == IDX_W'(IDX_SET_YR));
  assign run       = cnt_en && osc_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_en <= 1'b0;
      cnt_en <= 1'b0;
      osc_en <= 1'b0;
    end else if (bus_we && widx == IDX_W'(IDX_CTRL)) begin
      sec_en <= bus_wdata[BIT_SEC_EN];
      cnt_en <= bus_wdata[BIT_CNT_EN];
      osc_en <= bus_wdata[BIT_OSC_EN];
    end
  end

  always_comb begin
    ctrl_view             = '0;
    ctrl_view[BIT_SEC_EN] = sec_en;
    ctrl_view[BIT_CNT_EN] = cnt_en;
    ctrl_view[BIT_OSC_EN] = osc_en;
  end

  always_comb begin
    case (widx)
      IDX_W'(IDX_CTRL):   bus_rdata = ctrl_view;
      IDX_W'(IDX_GET_LO): bus_rdata = low_out;
      IDX_W'(IDX_GET_YR): bus_rdata = year_out;
      default:            bus_rdata = '0;
    endcase
  end

  toy_prescaler #(.TICKS_PER_STEP(TICKS_PER_STEP)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (osc_tick),
    .clear (load_low),
    .step  (step)
  );

  toy_calendar u_cal (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .load_low  (load_low),
    .low_in    (bus_wdata),
    .load_year (load_year),
    .year_in   (bus_wdata),
    .low_out   (low_out),
    .year_out  (year_out)
  );

  a_r3_gated: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (cnt_en && osc_en));
  a_r11_readonly_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && widx == IDX_W'(IDX_GET_LO) && !step) |=> $stable(low_out));

endmodule

// File: tb/sim_toy_clock.sv
module sim_toy_clock;

  localparam int CLK_PERIOD = 10;
  localparam int T = 2;
  localparam logic [4:0] A_CTRL = 5'h00, A_TRIM = 5'h04, A_SLO = 5'h08,
                         A_SYR = 5'h0C, A_GLO = 5'h10, A_GYR = 5'h14;

  logic        clk = 1'b0, rst_n = 1'b0, osc_tick = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  toy_clock #(.TICKS_PER_STEP(T), .ADDR_W(5)) u0 (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  function automatic logic [31:0] pk(int mo, int d, int h, int mi, int s, int ss);
    return {6'(mo), 5'(d), 5'(h), 6'(mi), 6'(s), 4'(ss)};
  endfunction

  // month length from arithmetic, not a lookup
  function automatic int mlen(int m, int y);
    int base;
    base = 28 + ((m + m / 8) % 2) + (2 % m) + 2 * (1 / m);
    if (m == 2 && (y % 4) == 0) base = 29;
    return base;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic ticks(int n);
    osc_tick = 1'b1;
    repeat (n) @(negedge clk);
    osc_tick = 1'b0;
  endtask

  // one step from a given state; expected next computed by carries
  task automatic one_step(string req, int y, int mo, int d, int h, int mi, int s, int ss);
    logic [31:0] v;
    int ey, emo, ed, eh, emi, es, ess;
    ey = y; emo = mo; ed = d; eh = h; emi = mi; es = s; ess = ss + 1;
    if (ess == 16) begin ess = 0; es++; end
    if (es == 60) begin es = 0; emi++; end
    if (emi == 60) begin emi = 0; eh++; end
    if (eh == 24) begin eh = 0; ed++; end
    if (ed > mlen(mo, y)) begin ed = 1; emo++; end
    if (emo == 13) begin emo = 1; ey++; end
    wr(A_SYR, 32'(y));
    wr(A_SLO, pk(mo, d, h, mi, s, ss));
    ticks(T);
    rd(A_GLO, v); check(req, v, pk(emo, ed, eh, emi, es, ess));
    rd(A_GYR, v); check(req, v, 32'(ey));
  endtask

  initial begin
    logic [31:0] v;
    int yrs[4] = '{2023, 2024, 2100, 2001};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(A_GLO, v);  check("R1 time", v, 32'h0420_0000);
    rd(A_GYR, v);  check("R1 year", v, 32'h0);
    rd(A_CTRL, v); check("R1 ctrl", v, 32'h0);

    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); check("R2 ctrl mask", v, 32'h0000_2900);
    wr(A_CTRL, 32'h0000_0900);
    rd(A_CTRL, v); check("R2 ctrl value", v, 32'h0000_0900);

    wr(A_TRIM, 32'hDEAD_BEEF);
    rd(A_TRIM, v); check("R4 trim", v, 32'h0);
    rd(A_GLO, v);  check("R4 time untouched", v, 32'h0420_0000);

    // R3: gated by both bits
    wr(A_CTRL, 32'h0000_0800);
    wr(A_SLO, pk(3, 5, 7, 9, 11, 2));
    ticks(8 * T);
    rd(A_GLO, v); check("R3 count only", v, pk(3, 5, 7, 9, 11, 2));
    wr(A_CTRL, 32'h0000_0100);
    ticks(8 * T);
    rd(A_GLO, v); check("R3 osc only", v, pk(3, 5, 7, 9, 11, 2));
    wr(A_CTRL, 32'h0000_0900);
    ticks(T);
    rd(A_GLO, v); check("R3 both", v, pk(3, 5, 7, 9, 11, 3));

    // R5: sub-second stepping, sweep all 16 and wrap
    wr(A_SLO, pk(3, 5, 7, 9, 11, 0));
    for (int k = 1; k <= 16; k++) begin
      ticks(T);
      rd(A_GLO, v);
      check("R5 sub", v, pk(3, 5, 7, 9, 11 + k / 16, k % 16));
    end
    ticks(T - 1);
    rd(A_GLO, v); check("R5 partial", v, pk(3, 5, 7, 9, 12, 0));

    // R9: reload restarts prescaler; fields land in place
    wr(A_SLO, pk(12, 31, 23, 45, 30, 7));
    rd(A_GLO, v); check("R9 fields", v, 32'h33F7_B5E7);
    ticks(T - 1);
    wr(A_SLO, pk(12, 31, 23, 45, 30, 7));
    ticks(T - 1);
    rd(A_GLO, v); check("R9 restart", v, pk(12, 31, 23, 45, 30, 7));
    ticks(1);
    rd(A_GLO, v); check("R9 step", v, pk(12, 31, 23, 45, 30, 8));

    // R10: year alone
    wr(A_SYR, 32'hABCD_1234);
    rd(A_GYR, v); check("R10 year", v, 32'hABCD_1234);
    rd(A_GLO, v); check("R10 time kept", v, pk(12, 31, 23, 45, 30, 8));

    // R11: write-only read zero, read-only ignore writes
    rd(A_SLO, v); check("R11 set lo reads 0", v, 32'h0);
    rd(A_SYR, v); check("R11 set yr reads 0", v, 32'h0);
    wr(A_GLO, 32'h1111_1111);
    wr(A_GYR, 32'h2222_2222);
    rd(A_GLO, v); check("R11 get lo", v, pk(12, 31, 23, 45, 30, 8));
    rd(A_GYR, v); check("R11 get yr", v, 32'hABCD_1234);

    // R6: seconds, minutes, hours sweeps
    for (int s = 0; s < 60; s++) one_step("R6 sec", 2030, 5, 10, 4, 20, s, 15);
    for (int m = 0; m < 60; m++) one_step("R6 min", 2030, 5, 10, 4, m, 59, 15);
    for (int h = 0; h < 24; h++) one_step("R6 hour", 2030, 5, 10, h, 59, 59, 15);

    // R7 / R8: every month across leap, non-leap and century years
    foreach (yrs[i]) begin
      for (int m = 1; m <= 12; m++) begin
        one_step("R7 last day", yrs[i], m, mlen(m, yrs[i]), 23, 59, 59, 15);
        one_step("R7 day before last", yrs[i], m, mlen(m, yrs[i]) - 1, 23, 59, 59, 15);
      end
      one_step("R8 feb 28", yrs[i], 2, 28, 23, 59, 59, 15);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1..: actual=timeout expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule